// File: doc/BRIEF.md
# Idle-Gated Memory Access Window

This block sits between a host's simple request/response bus and the two memories of an accelerator. It decodes a byte address space in which the instruction memory and the data memory each take one 16 KiB region. It forwards full-word host reads and writes to the matching memory port, but only while the accelerator reports that it is neither busy nor locked.

While the accelerator is running or locked, the memories are hidden from the host. Reads return zero and writes are discarded. An access made while the accelerator is running also raises a one-cycle illegal-access fatal flag. An access made while it is locked raises no new error.

The data window exposes only the lower half of the physical data memory. Word indices inside a region that lie past the populated words are answered with zero data and a bus error. Every request is answered exactly one cycle after it is presented.

Top module: `mem_window_gate`

## Requirements
- R1: After reset, `rsp_valid` and `illegal_access` are 0. The memory strobes stay low while no request is presented.
- R2: When idle, a read at byte address 0x4000 + 4·k with k < 1024 returns instruction word k on `rsp_rdata`. The response comes one cycle after the request, with `rsp_valid` high and `rsp_err` low.
- R3: When idle, a write to the instruction window stores `req_wdata` at word k = addr[11:2]. A later read of the same address returns the stored value.
- R4: When idle, the data window at 0x8000 + 4·k, with k < 512, reads and writes physical data word k. Word index bit 9 on `dmem_addr` is always 0, so the upper half of the physical memory is never reached.
- R5: An address inside a window region but past its populated words reads 0, raises `rsp_err`, and leaves both memories unchanged. For the instruction region these are words 1024 to 4095; for the data region they are words 512 to 4095.
- R6: Any request while `acc_busy` is high and `acc_locked` is low returns 0 and drops writes. It also pulses `illegal_access` for one cycle, in the response cycle.
- R7: Any request while `acc_locked` is high returns 0, drops writes, and leaves `illegal_access` low, whatever the value of `acc_busy`.
- R8: Addresses outside both regions (top two address bits 00 or 11) read 0 and raise `rsp_err`.
- R9: Every request cycle produces `rsp_valid` in the next cycle. A cycle without a request produces none. Back-to-back requests each receive their own response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_busy | input | 1 | Accelerator is running an operation |
| acc_locked | input | 1 | Accelerator is locked after a fatal error |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host byte address |
| req_wdata | input | 32 | Host write word |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read word, 0 when not forwarded |
| rsp_err | output | 1 | Address decode miss |
| illegal_access | output | 1 | Fatal pulse: access while busy |
| imem_req | output | 1 | Instruction memory access strobe |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | 10 | Instruction memory word index |
| imem_wdata | output | 32 | Instruction memory write word |
| imem_rdata | input | 32 | Instruction memory read word, one cycle after strobe |
| dmem_req | output | 1 | Data memory access strobe |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 10 | Data memory word index (physical) |
| dmem_wdata | output | 32 | Data memory write word |
| dmem_rdata | input | 32 | Data memory read word, one cycle after strobe |

## Verification
The decode-miss error and the busy fatal flag are produced by separate conditions, and both can belong to one request. The bench provokes this by presenting an out-of-range address in the instruction region while `acc_busy` is high. It then requires `rsp_err` and `illegal_access` to be high together in the response cycle, with zero read data. The same request repeated under `acc_locked` must show the error without the fatal flag, which confirms that lock takes priority over busy.

// File: rtl/mem_window_gate.sv
module mem_window_gate #(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 32,
  parameter int REGION_W       = 14,
  parameter int IMEM_SEL       = 1,
  parameter int DMEM_SEL       = 2,
  parameter int IMEM_WORDS     = 1024,
  parameter int DMEM_WORDS     = 1024,
  parameter int DMEM_VIS_WORDS = 512,
  localparam int IMEM_AW = $clog2(IMEM_WORDS),
  localparam int DMEM_AW = $clog2(DMEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_busy,
  input  logic              acc_locked,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              illegal_access,
  output logic              imem_req,
  output logic              imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [DATA_W-1:0] imem_wdata,
  input  logic [DATA_W-1:0] imem_rdata,
  output logic              dmem_req,
  output logic              dmem_we,
  output logic [DMEM_AW-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata
);
  localparam int SEL_W    = ADDR_W - REGION_W;
  localparam int IDX_W    = REGION_W - 2;
  localparam int DVIS_AW  = $clog2(DMEM_VIS_WORDS);

  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx;
  logic hit_i, hit_d, open;
  logic rd_i_q, rd_d_q;
  logic unused_lsb;

  assign sel   = req_addr[ADDR_W-1:REGION_W];
  assign idx   = req_addr[REGION_W-1:2];
  assign unused_lsb = ^req_addr[1:0];

  assign hit_i = (sel == SEL_W'(IMEM_SEL)) && ({1'b0, idx} < (IDX_W+1)'(IMEM_WORDS));
  assign hit_d = (sel == SEL_W'(DMEM_SEL)) && ({1'b0, idx} < (IDX_W+1)'(DMEM_VIS_WORDS));
  assign open  = !acc_busy && !acc_locked;

  assign imem_req   = req_valid && hit_i && open;
  assign imem_we    = imem_req && req_write;
  assign imem_addr  = idx[IMEM_AW-1:0];
  assign imem_wdata = req_wdata;

  assign dmem_req   = req_valid && hit_d && open;
  assign dmem_we    = dmem_req && req_write;
  assign dmem_addr  = DMEM_AW'(idx[DVIS_AW-1:0]);
  assign dmem_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_err        <= 1'b0;
      illegal_access <= 1'b0;
      rd_i_q         <= 1'b0;
      rd_d_q         <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_err        <= req_valid && !(hit_i || hit_d);
      illegal_access <= req_valid && acc_busy && !acc_locked;
      rd_i_q         <= imem_req && !req_write;
      rd_d_q         <= dmem_req && !req_write;
    end
  end

  assign rsp_rdata = rd_i_q ? imem_rdata : rd_d_q ? dmem_rdata : '0;
endmodule

// File: rtl/mem_window_gate_chk.sv
module mem_window_gate_chk #(
  parameter int DATA_W         = 32,
  parameter int DMEM_AW        = 10,
  parameter int DMEM_VIS_WORDS = 512
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_busy,
  input logic               acc_locked,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               rsp_err,
  input logic               illegal_access,
  input logic               imem_req,
  input logic               dmem_req,
  input logic [DMEM_AW-1:0] dmem_addr
);
  a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r9_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r1_no_strobe_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !imem_req && !dmem_req);
  a_r6_blocked_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_busy || acc_locked) |-> !imem_req && !dmem_req);
  a_r6_busy_flags_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_busy && !acc_locked) |=> illegal_access);
  a_r7_locked_no_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    acc_locked |=> !illegal_access);
  a_r4_lower_half_only: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req |-> dmem_addr < DMEM_AW'(DMEM_VIS_WORDS));
  a_r5_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == '0);
  a_r6_fatal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_access |-> rsp_rdata == '0);
endmodule

bind mem_window_gate mem_window_gate_chk #(
  .DATA_W(DATA_W), .DMEM_AW(DMEM_AW), .DMEM_VIS_WORDS(DMEM_VIS_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_busy(acc_busy), .acc_locked(acc_locked),
  .req_valid(req_valid), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .illegal_access(illegal_access), .imem_req(imem_req),
  .dmem_req(dmem_req), .dmem_addr(dmem_addr)
);

// File: tb/mem_window_gate_bench.sv
module mem_window_gate_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_busy = 1'b0, acc_locked = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, illegal_access;
  logic [31:0] rsp_rdata;
  logic imem_req, imem_we, dmem_req, dmem_we;
  logic [9:0] imem_addr, dmem_addr;
  logic [31:0] imem_wdata, dmem_wdata, imem_rdata, dmem_rdata;

  logic [31:0] imem [1024];
  logic [31:0] dmem [1024];

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [31:0] g_data;
  logic g_vld, g_err, g_ill;

  always #(PERIOD/2) clk = ~clk;

  mem_window_gate u_mem_window_gate (
    .clk(clk), .rst_n(rst_n), .acc_busy(acc_busy), .acc_locked(acc_locked),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .illegal_access(illegal_access),
    .imem_req(imem_req), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .imem_rdata(imem_rdata),
    .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  always @(posedge clk) begin
    if (imem_req) begin
      if (imem_we) imem[imem_addr] <= imem_wdata;
      imem_rdata <= imem[imem_addr];
    end
    if (dmem_req) begin
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
      dmem_rdata <= dmem[dmem_addr];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(bit w, logic [15:0] a, logic [31:0] d, bit busy, bit lock);
    @(negedge clk);
    acc_busy = busy; acc_locked = lock;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; acc_busy = 1'b0; acc_locked = 1'b0;
    g_vld = rsp_valid; g_data = rsp_rdata; g_err = rsp_err; g_ill = illegal_access;
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid at reset", 32'(rsp_valid), 0);
    chk("R1 illegal_access at reset", 32'(illegal_access), 0);
    chk("R1 no strobes", 32'(imem_req | dmem_req), 0);
  endtask

  task automatic t_imem;
    access(0, 16'h4000 + 16'd4*7, 0, 0, 0);
    chk("R2 imem read word 7", g_data, 32'hA000_0007);
    chk("R2 rsp_valid", 32'(g_vld), 1);
    chk("R2 no error", 32'(g_err), 0);
    access(1, 16'h4014, 32'h1234_5678, 0, 0);
    access(0, 16'h4014, 0, 0, 0);
    chk("R3 imem write/readback", g_data, 32'h1234_5678);
    access(1, 16'h4FFC, 32'hCAFE_0001, 0, 0);
    access(0, 16'h4FFC, 0, 0, 0);
    chk("R3 imem last word", g_data, 32'hCAFE_0001);
  endtask

  task automatic t_dmem;
    access(0, 16'h8000 + 16'd4*3, 0, 0, 0);
    chk("R4 dmem read word 3", g_data, 32'hD000_0003);
    access(1, 16'h87FC, 32'h0BAD_F00D, 0, 0);
    access(0, 16'h87FC, 0, 0, 0);
    chk("R4 dmem last visible word", g_data, 32'h0BAD_F00D);
    chk("R4 physical word 511 written", dmem[511], 32'h0BAD_F00D);
    chk("R4 physical word 1023 untouched", dmem[1023], 32'hD000_03FF);
  endtask

  task automatic t_out_of_range;
    access(0, 16'h5000, 0, 0, 0);
    chk("R5 imem gap read zero", g_data, 0);
    chk("R5 imem gap error", 32'(g_err), 1);
    access(1, 16'h5000, 32'hFFFF_FFFF, 0, 0);
    access(0, 16'h4000, 0, 0, 0);
    chk("R5 imem gap write no alias", g_data, 32'hA000_0000);
    access(1, 16'h8800, 32'hEEEE_EEEE, 0, 0);
    chk("R5 dmem gap error", 32'(g_err), 1);
    chk("R5 dmem word 0 kept", dmem[0], 32'hD000_0000);
    chk("R5 dmem word 512 kept", dmem[512], 32'hD000_0200);
    access(0, 16'h0010, 0, 0, 0);
    chk("R8 low region error", 32'(g_err), 1);
    chk("R8 low region zero", g_data, 0);
    access(0, 16'hC000, 0, 0, 0);
    chk("R8 high region error", 32'(g_err), 1);
  endtask

  task automatic t_busy;
    access(0, 16'h4000 + 16'd4*9, 0, 1, 0);
    chk("R6 busy read zero", g_data, 0);
    chk("R6 busy fatal", 32'(g_ill), 1);
    chk("R6 busy no decode error", 32'(g_err), 0);
    @(negedge clk);
    chk("R6 fatal is one pulse", 32'(illegal_access), 0);
    access(1, 16'h8008, 32'h5555_AAAA, 1, 0);
    access(0, 16'h8008, 0, 0, 0);
    chk("R6 busy write dropped", g_data, 32'hD000_0002);
  endtask

  task automatic t_locked;
    access(0, 16'h4000 + 16'd4*9, 0, 0, 1);
    chk("R7 locked read zero", g_data, 0);
    chk("R7 locked no fatal", 32'(g_ill), 0);
    access(1, 16'h4024, 32'h7777_7777, 1, 1);
    chk("R7 locked+busy no fatal", 32'(g_ill), 0);
    access(0, 16'h4024, 0, 0, 0);
    chk("R7 locked write dropped", g_data, 32'hA000_0009);
  endtask

  task automatic t_overlap;
    access(0, 16'h7000, 0, 1, 0);
    chk("R5 busy miss error", 32'(g_err), 1);
    chk("R6 busy miss fatal", 32'(g_ill), 1);
    chk("R6 busy miss zero", g_data, 0);
    access(0, 16'h7000, 0, 1, 1);
    chk("R7 locked miss no fatal", 32'(g_ill), 0);
    chk("R5 locked miss error", 32'(g_err), 1);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 16'h4008;
    @(negedge clk);
    chk("R9 first response valid", 32'(rsp_valid), 1);
    chk("R9 first data", rsp_rdata, 32'hA000_0002);
    req_addr = 16'h8004;
    @(negedge clk);
    req_valid = 0;
    chk("R9 second response valid", 32'(rsp_valid), 1);
    chk("R9 second data", rsp_rdata, 32'hD000_0001);
    @(negedge clk);
    chk("R9 no request no response", 32'(rsp_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      imem[i] = 32'hA000_0000 | 32'(i);
      dmem[i] = 32'hD000_0000 | 32'(i);
    end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_imem;
    t_dmem;
    t_out_of_range;
    t_busy;
    t_locked;
    t_overlap;
    t_back_to_back;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule